// File: doc/BRIEF.md
# Store Distance Dependence Table

This block sits beside the decode stage of an out-of-order core and tells each decoded load which in-flight store it should wait for. Every store decoded in program order pushes its reorder-buffer (ROB) ID into a 16-entry circular buffer. A pointer tracks the position of the most recent store. Each load carries a 4-bit store distance that the compiler placed in the instruction. Distance n selects the store n positions back from the pointer, which is the (n+1)-th most recent store. The value 15 marks a load that is always speculated and has no producer.

The lookup result is registered and appears one cycle after the load is decoded. It gives the load's ROB ID, a dependence flag, a blind-speculation flag and the producer ID, and it is meant to be written into the load's ROB entry. A lookup reports no dependence when the selected entry is invalid or when the producer is already older than the ROB head. A separate combinational issue check is used by the oldest-to-youngest scheduler scan. A store issues when its address is computed and a memory port is free. A load also needs its predicted producer to be ready, unless the load is blind or has no live producer. A pipeline rollback clears every entry.

Top module: `sdt_top`

## Requirements
- R1: After reset `res_valid` is 0 and every table entry is invalid, so a load decoded before any store returns `res_has_dep`=0.
- R2: A decoded store (`dec_is_store`=1) advances the most-recent pointer by one, modulo 16, and records its ROB ID there. A store produces no lookup result (`res_valid` stays 0 the next cycle).
- R3: A load decoded with distance n (0..14) produces, one cycle later, `res_valid`=1, `res_rob_id` equal to the load ID, and `res_prod_id` equal to the ID of the (n+1)-th most recent store, with wraparound over the 16 entries. `res_has_dep`=1 when that entry is valid and the producer is live.
- R4: A load with distance 15 gets `res_blind`=1 and `res_has_dep`=0. Any other distance gives `res_blind`=0.
- R5: A load whose selected entry has not been written since reset or since the last rollback gets `res_has_dep`=0.
- R6: The producer is live only if ((prod − rob_head) mod 256) < ((load − rob_head) mod 256). Otherwise `res_has_dep`=0.
- R7: `flush`=1 invalidates all entries and leaves the pointer unchanged. A decode presented in the same cycle is dropped: no table write and no lookup result.
- R8: `q_issue` = `q_valid` & `q_addr_done` & `q_port_free` & (`q_is_store` | `q_blind` | !`q_has_dep` | producer not live per the R6 rule using `q_rob_id` | `store_ready[q_prod_id]`).
- R9: Stores with IDs 1, 2 and 4 are decoded with a distance-15 load between the second and third store. A load with distance 2 that follows them returns producer ID 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dec_valid | input | 1 | A memory instruction is decoded this cycle |
| dec_is_store | input | 1 | 1 = store, 0 = load |
| dec_rob_id | input | 8 | ROB ID of the decoded instruction |
| dec_dist | input | 4 | Store distance of a load (15 = blind) |
| rob_head | input | 8 | ROB ID of the oldest in-flight instruction |
| flush | input | 1 | Rollback: invalidate the table, drop this cycle's decode |
| res_valid | output | 1 | Lookup result valid (one cycle after a load decode) |
| res_rob_id | output | 8 | ROB ID of the looked-up load |
| res_has_dep | output | 1 | Load must wait for `res_prod_id` |
| res_blind | output | 1 | Load is always speculated |
| res_prod_id | output | 8 | Predicted producer store ROB ID |
| q_valid | input | 1 | Issue query valid |
| q_is_store | input | 1 | Queried entry is a store |
| q_addr_done | input | 1 | Queried entry has its address computed |
| q_port_free | input | 1 | A memory port is available |
| q_rob_id | input | 8 | ROB ID of the queried entry |
| q_has_dep | input | 1 | Stored dependence flag of the queried load |
| q_blind | input | 1 | Stored blind flag of the queried load |
| q_prod_id | input | 8 | Stored producer ID of the queried load |
| store_ready | input | 256 | Per ROB entry: store is ready |
| q_issue | output | 1 | Queried entry may issue now |

## Verification
The lookup is tried with a run of 20 stores, so the buffer wraps, followed by loads at every distance 0..15. This separates pointer arithmetic, wraparound and the blind code. The same sweep is repeated with the ROB head moved into the middle of the stored IDs, which separates live producers from retired ones. A rollback sequence with a store decoded in the flush cycle shows that entries are invalidated, that the pointer is kept, and that the same-cycle decode is dropped. The issue check is swept over all 256 combinations of its control inputs and producer age. The ready vector holds the opposite value at every other index, so a wrong index shows up as a wrong result.

// File: rtl/sdt_pkg.sv
package sdt_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_STORE = 2'd1,
    OP_LOAD  = 2'd2
  } dec_op_e;
endpackage

// File: rtl/sdt_age.sv
module sdt_age #(
  parameter int ID_W = 8
) (
  input  logic [ID_W-1:0] head,
  input  logic [ID_W-1:0] older_id,
  input  logic [ID_W-1:0] younger_id,
  output logic            is_live
);
  logic [ID_W-1:0] off_old;
  logic [ID_W-1:0] off_young;

  always_comb begin
    off_old   = older_id - head;
    off_young = younger_id - head;
    is_live   = off_old < off_young;
  end
endmodule

// File: rtl/sdt_ring.sv
module sdt_ring #(
  parameter int DEPTH = 16,
  parameter int ID_W  = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [ID_W-1:0]  wr_id,
  input  logic             clr,
  input  logic [IDX_W-1:0] rd_dist,
  output logic [ID_W-1:0]  rd_id,
  output logic             rd_hit
);
  logic [IDX_W-1:0] cur_q, cur_d;
  logic [DEPTH-1:0] val_q, val_d;
  logic [ID_W-1:0]  ids_q [DEPTH];
  logic [IDX_W-1:0] rd_idx;
  logic [IDX_W-1:0] wr_idx;

  always_comb begin
    wr_idx = cur_q + 1'b1;
    cur_d  = cur_q;
    val_d  = val_q;
    if (clr) begin
      val_d = '0;
    end else if (wr_en) begin
      cur_d         = wr_idx;
      val_d[wr_idx] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= '0;
      val_q <= '0;
    end else begin
      cur_q <= cur_d;
      val_q <= val_d;
    end
  end

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    logic we;
    assign we = wr_en && !clr && (wr_idx == IDX_W'(e));
    always_ff @(posedge clk) begin
      if (we) ids_q[e] <= wr_id;
    end
  end

  always_comb begin
    rd_idx = cur_q - rd_dist;
    rd_id  = ids_q[rd_idx];
    rd_hit = val_q[rd_idx];
  end

  // R2
  cur_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !clr) |=> (cur_q == $past(cur_q) + 1'b1) && val_q[cur_q]);

  // R7
  clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (val_q == '0) && $stable(cur_q));
endmodule

// File: rtl/sdt_gate.sv
module sdt_gate #(
  parameter int ID_W = 8,
  localparam int ROB_DEPTH = 1 << ID_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 q_valid,
  input  logic                 q_is_store,
  input  logic                 q_addr_done,
  input  logic                 q_port_free,
  input  logic [ID_W-1:0]      q_rob_id,
  input  logic                 q_has_dep,
  input  logic                 q_blind,
  input  logic [ID_W-1:0]      q_prod_id,
  input  logic [ID_W-1:0]      rob_head,
  input  logic [ROB_DEPTH-1:0] store_ready,
  output logic                 q_issue
);
  logic prod_live;
  logic dep_clear;

  sdt_age #(.ID_W(ID_W)) u_age (
    .head       (rob_head),
    .older_id   (q_prod_id),
    .younger_id (q_rob_id),
    .is_live    (prod_live)
  );

  always_comb begin
    dep_clear = q_is_store || q_blind || !q_has_dep || !prod_live ||
                store_ready[q_prod_id];
    q_issue   = q_valid && q_addr_done && q_port_free && dep_clear;
  end

  // R8
  issue_needs_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_issue |-> (q_addr_done && q_port_free && q_valid));

  // R8
  wait_on_producer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q_valid && !q_is_store && !q_blind && q_has_dep && prod_live &&
     !store_ready[q_prod_id]) |-> !q_issue);
endmodule

// File: rtl/sdt_top.sv
module sdt_top #(
  parameter int ID_W       = 8,
  parameter int RING_DEPTH = 16,
  localparam int DIST_W    = $clog2(RING_DEPTH),
  localparam int ROB_DEPTH = 1 << ID_W,
  localparam int SPEC_DIST = RING_DEPTH - 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 dec_valid,
  input  logic                 dec_is_store,
  input  logic [ID_W-1:0]      dec_rob_id,
  input  logic [DIST_W-1:0]    dec_dist,
  input  logic [ID_W-1:0]      rob_head,
  input  logic                 flush,
  output logic                 res_valid,
  output logic [ID_W-1:0]      res_rob_id,
  output logic                 res_has_dep,
  output logic                 res_blind,
  output logic [ID_W-1:0]      res_prod_id,
  input  logic                 q_valid,
  input  logic                 q_is_store,
  input  logic                 q_addr_done,
  input  logic                 q_port_free,
  input  logic [ID_W-1:0]      q_rob_id,
  input  logic                 q_has_dep,
  input  logic                 q_blind,
  input  logic [ID_W-1:0]      q_prod_id,
  input  logic [ROB_DEPTH-1:0] store_ready,
  output logic                 q_issue
);
  import sdt_pkg::*;

  dec_op_e         op;
  logic [ID_W-1:0] rd_id;
  logic            rd_hit;
  logic            prod_live;
  logic            is_blind;
  logic            dep_d;

  logic            rv_q, rv_d;
  logic [ID_W-1:0] rid_q, rid_d;
  logic            rdep_q, rdep_d;
  logic            rbl_q, rbl_d;
  logic [ID_W-1:0] rpid_q, rpid_d;

  always_comb begin
    if (!dec_valid || flush) op = OP_IDLE;
    else if (dec_is_store)   op = OP_STORE;
    else                     op = OP_LOAD;
  end

  sdt_ring #(.DEPTH(RING_DEPTH), .ID_W(ID_W)) u_ring (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (op == OP_STORE),
    .wr_id   (dec_rob_id),
    .clr     (flush),
    .rd_dist (dec_dist),
    .rd_id   (rd_id),
    .rd_hit  (rd_hit)
  );

  sdt_age #(.ID_W(ID_W)) u_dec_age (
    .head       (rob_head),
    .older_id   (rd_id),
    .younger_id (dec_rob_id),
    .is_live    (prod_live)
  );

  always_comb begin
    is_blind = dec_dist == DIST_W'(SPEC_DIST);
    dep_d    = !is_blind && rd_hit && prod_live;
    rv_d     = op == OP_LOAD;
    rid_d    = rid_q;
    rdep_d   = rdep_q;
    rbl_d    = rbl_q;
    rpid_d   = rpid_q;
    if (op == OP_LOAD) begin
      rid_d  = dec_rob_id;
      rdep_d = dep_d;
      rbl_d  = is_blind;
      rpid_d = rd_id;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rv_q   <= 1'b0;
      rid_q  <= '0;
      rdep_q <= 1'b0;
      rbl_q  <= 1'b0;
      rpid_q <= '0;
    end else begin
      rv_q   <= rv_d;
      rid_q  <= rid_d;
      rdep_q <= rdep_d;
      rbl_q  <= rbl_d;
      rpid_q <= rpid_d;
    end
  end

  assign res_valid   = rv_q;
  assign res_rob_id  = rid_q;
  assign res_has_dep = rdep_q;
  assign res_blind   = rbl_q;
  assign res_prod_id = rpid_q;

  sdt_gate #(.ID_W(ID_W)) u_gate (
    .clk         (clk),
    .rst_n       (rst_n),
    .q_valid     (q_valid),
    .q_is_store  (q_is_store),
    .q_addr_done (q_addr_done),
    .q_port_free (q_port_free),
    .q_rob_id    (q_rob_id),
    .q_has_dep   (q_has_dep),
    .q_blind     (q_blind),
    .q_prod_id   (q_prod_id),
    .rob_head    (rob_head),
    .store_ready (store_ready),
    .q_issue     (q_issue)
  );

  // R4
  blind_no_dep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_blind) |-> !res_has_dep);

  // R7
  flush_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !res_valid);

  // R2
  store_no_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_is_store) |=> !res_valid);

  // R3
  load_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && !dec_is_store && !flush) |=>
      res_valid && (res_rob_id == $past(dec_rob_id)));
endmodule

// File: tb/sdt_top_tb_top.sv
module sdt_top_tb_top;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         dec_valid, dec_is_store, flush;
  logic [7:0]   dec_rob_id, rob_head;
  logic [3:0]   dec_dist;
  logic         res_valid, res_has_dep, res_blind;
  logic [7:0]   res_rob_id, res_prod_id;
  logic         q_valid, q_is_store, q_addr_done, q_port_free, q_has_dep, q_blind;
  logic [7:0]   q_rob_id, q_prod_id;
  logic [255:0] store_ready;
  logic         q_issue;

  int tests = 0;
  int fails = 0;

  logic [7:0] m_id [16];
  logic       m_v  [16];
  logic [3:0] m_cur;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdt_top dut_i (
    .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_is_store(dec_is_store),
    .dec_rob_id(dec_rob_id), .dec_dist(dec_dist), .rob_head(rob_head), .flush(flush),
    .res_valid(res_valid), .res_rob_id(res_rob_id), .res_has_dep(res_has_dep),
    .res_blind(res_blind), .res_prod_id(res_prod_id), .q_valid(q_valid),
    .q_is_store(q_is_store), .q_addr_done(q_addr_done), .q_port_free(q_port_free),
    .q_rob_id(q_rob_id), .q_has_dep(q_has_dep), .q_blind(q_blind),
    .q_prod_id(q_prod_id), .store_ready(store_ready), .q_issue(q_issue)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic live(input logic [7:0] p, input logic [7:0] l, input logic [7:0] h);
    logic [7:0] a, b;
    a = p - h;
    b = l - h;
    return a < b;
  endfunction

  task automatic dec(input logic st, input logic [7:0] id, input logic [3:0] d, input string tag);
    logic [3:0] ix;
    logic       e_bl, e_dep;
    logic [7:0] e_pid;
    ix    = m_cur - d;
    e_bl  = (d == 4'd15);
    e_pid = m_id[ix];
    e_dep = !e_bl && m_v[ix] && live(e_pid, id, rob_head);
    dec_valid = 1'b1; dec_is_store = st; dec_rob_id = id; dec_dist = d;
    @(negedge clk);
    if (st) begin
      chk({tag, " R2 store no result"}, res_valid, 0);
      m_cur = m_cur + 1'b1;
      m_id[m_cur] = id;
      m_v[m_cur]  = 1'b1;
    end else begin
      chk({tag, " R3 valid"}, res_valid, 1);
      chk({tag, " R3 load id"}, res_rob_id, id);
      chk({tag, " R4 blind"}, res_blind, e_bl);
      chk({tag, " R3/R5/R6 dep"}, res_has_dep, e_dep);
      if (e_dep) chk({tag, " R3 producer"}, res_prod_id, e_pid);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; dec_valid = 0; dec_is_store = 0; dec_rob_id = 0; dec_dist = 0;
    rob_head = 0; flush = 0; q_valid = 0; q_is_store = 0; q_addr_done = 0;
    q_port_free = 0; q_rob_id = 0; q_has_dep = 0; q_blind = 0; q_prod_id = 0;
    store_ready = '0;
    m_cur = 0;
    for (int i = 0; i < 16; i++) begin m_v[i] = 0; m_id[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset res_valid", res_valid, 0);
    dec(0, 8'd40, 4'd0, "R1 load after reset");
    chk("R1/R5 no dep after reset", res_has_dep, 0);

    // R9 worked example
    dec(1, 8'd1, 4'd0, "R9");
    dec(1, 8'd2, 4'd0, "R9");
    dec(0, 8'd3, 4'd15, "R9 blind");
    dec(1, 8'd4, 4'd0, "R9");
    dec(0, 8'd5, 4'd2, "R9");
    chk("R9 producer is ID1", res_prod_id, 8'd1);
    chk("R9 has dep", res_has_dep, 1);

    // R3/R4 wrap sweep, then R6 with head moved
    for (int k = 0; k < 20; k++) dec(1, 8'(10 + k), 4'd0, "R2 fill");
    for (int pass = 0; pass < 2; pass++) begin
      rob_head = (pass == 0) ? 8'd0 : 8'd25;
      for (int d = 0; d < 16; d++) dec(0, 8'd200, 4'(d), pass == 0 ? "R3 sweep" : "R6 sweep");
    end
    rob_head = 0;

    // R7 flush with a store in the same cycle
    dec_valid = 1; dec_is_store = 1; dec_rob_id = 8'd77; dec_dist = 0; flush = 1;
    @(negedge clk);
    flush = 0;
    chk("R7 flush no result", res_valid, 0);
    for (int i = 0; i < 16; i++) m_v[i] = 0;
    dec(0, 8'd120, 4'd0, "R7 after flush");
    chk("R7 entry cleared", res_has_dep, 0);
    dec(1, 8'd90, 4'd0, "R7");
    dec(0, 8'd121, 4'd0, "R7 new store");
    chk("R7 new store seen", res_prod_id, 8'd90);
    dec(0, 8'd122, 4'd1, "R7/R5 older invalid");
    chk("R5 invalid entry", res_has_dep, 0);
    dec_valid = 0;
    @(negedge clk);
    chk("R3 no load no result", res_valid, 0);

    // R8 exhaustive issue check
    rob_head = 0; q_rob_id = 8'd100;
    for (int c = 0; c < 256; c++) begin
      logic rdy, stale, exp;
      q_valid = c[0]; q_is_store = c[1]; q_addr_done = c[2]; q_port_free = c[3];
      q_blind = c[4]; q_has_dep = c[5]; rdy = c[6]; stale = c[7];
      q_prod_id = stale ? 8'd150 : 8'd50;
      store_ready = rdy ? '0 : '1;
      store_ready[q_prod_id] = rdy;
      exp = c[0] && c[2] && c[3] && (c[1] || c[4] || !c[5] || stale || rdy);
      #1;
      chk("R8 issue", q_issue, exp);
      @(negedge clk);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule